// File: doc/BRIEF.md
# Bridge Transaction Forwarding Decoder

This block sits beside the address phase of a two-port bus bridge. For each transaction it decides whether the bridge should claim it and carry it to the other side. A transaction has an address, an I/O-or-memory flag and a direction. It either arrives on the primary side and may go downstream, or it arrives on the secondary side and may go upstream. The block holds a six-bit bridge control word and an inclusive I/O window made of a base and a limit. The decision comes out registered, one clock after the transaction is presented, together with a valid strobe.

The decision has three parts:
- The I/O window claims downstream I/O.
- A legacy-alias suppression mode cuts holes into that window. Addresses in those holes are sent upstream instead.
- A display-compatibility override claims the legacy display memory and I/O ranges for the downstream side, whatever the window says.

A secondary-side address is forwarded upstream exactly when the downstream decode would not claim it.

The block also handles three error paths:
- It picks how a master abort on the secondary side is completed. It is either hidden, or reported as a target abort.
- It gates the secondary system-error input onto the primary system-error request.
- It gates the reporting of secondary parity errors.

Top module: `bridge_fwd_decoder`

## Requirements
- R1: After reset the control word reads 0, `dec_valid`, `fwd_down` and `fwd_up` are 0, and the I/O window is empty (base all ones, limit 0), so no I/O address is claimed by the window.
- R2: Control bit 4 is reserved. It always reads 0, and writing 1 to it changes no output. The other control bits are: bit 0 parity response, bit 1 secondary error forwarding, bit 2 alias suppression, bit 3 display override, bit 5 master-abort mode.
- R3: `dec_valid` is `txn_valid` delayed by one clock. `fwd_down` and `fwd_up` are never both 1, and both are 0 when `dec_valid` is 0. The decision uses the register contents at the clock edge where the transaction is sampled.
- R4: With alias suppression off, a primary-side I/O address A with base <= A <= limit is forwarded downstream. An address outside that range is not, unless R7 applies.
- R5: With alias suppression on, a window address below 0x10000 whose bits [9:8] are not 00 is not forwarded downstream, unless R7 applies. Window addresses at or above 0x10000, or with bits [9:8] = 00, are still forwarded.
- R6: A secondary-side transaction is forwarded upstream exactly when a primary-side transaction of the same type and address would not be forwarded downstream. This includes I/O addresses outside the window and I/O addresses in the suppressed holes.
- R7: With the display override on (bit 3), I/O addresses whose low 10 bits are in 0x3B0..0x3BB or 0x3C0..0x3DF are claimed for downstream regardless of window and suppression. With it off, these addresses get no special treatment.
- R8: A memory transaction is claimed for downstream only when the display override is on and the address is in 0xA0000..0xBFFFF. All other memory addresses are forwarded upstream from the secondary side.
- R9: With master-abort mode 0, a secondary master abort (`sec_ma`) raises `ma_fill_ones` for a read (data completes as 0xFFFF_FFFF) or `ma_drop_write` for a write. `ma_target_abort` stays 0.
- R10: With master-abort mode 1, `sec_ma` raises `ma_target_abort`, lowers `ma_fill_ones` and `ma_drop_write`, and raises `pri_serr` when `pri_serr_en` is 1.
- R11: `sec_serr` reaches `pri_serr` only when control bit 1 is 1.
- R12: `perr_report` follows `sec_perr` when control bit 0 is 1, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 6 | Control word write data |
| ctrl_rdata | output | 6 | Control word read-back |
| win_we | input | 1 | Write strobe for the I/O window |
| win_base | input | AW | New window base (inclusive) |
| win_limit | input | AW | New window limit (inclusive) |
| txn_valid | input | 1 | A transaction address is present |
| txn_addr | input | AW | Transaction address |
| txn_is_io | input | 1 | 1 = I/O transaction, 0 = memory |
| txn_from_sec | input | 1 | 1 = seen on secondary side, 0 = primary side |
| dec_valid | output | 1 | Decision strobe, one clock after `txn_valid` |
| fwd_down | output | 1 | Claim and forward downstream |
| fwd_up | output | 1 | Claim and forward upstream |
| sec_ma | input | 1 | Master abort seen on the secondary side |
| sec_ma_read | input | 1 | The aborted transaction was a read |
| pri_serr_en | input | 1 | Primary system-error reporting enabled |
| sec_serr | input | 1 | Secondary system-error input |
| sec_perr | input | 1 | Secondary parity error detected |
| ma_fill_ones | output | 1 | Complete the aborted read with all-ones data |
| ma_drop_write | output | 1 | Discard the aborted write data |
| ma_target_abort | output | 1 | Report the abort as target abort |
| pri_serr | output | 1 | Primary system-error request |
| perr_report | output | 1 | Report a secondary parity error |

## Verification
The hardest cases are where the three claim rules meet: a display-range I/O alias inside a suppressed hole, inside or outside the window, seen from both sides. Another is a hole edge (offset 0x0FF against 0x100, 0xFFFF against 0x10000) right at the window base or limit. Random stimulus almost never lands on these. The bench therefore programs windows whose edges sit on 1 KB boundaries and around 0x10000. It then walks addresses built from a block index plus offsets picked from the edge and display-range lists, under every combination of the suppression and override bits. A reference model checks the result every clock.

// File: rtl/bfd_pkg.sv
package bfd_pkg;

  localparam int CTRL_W = 6;

  typedef struct packed {
    logic ma_mode;    // bit 5
    logic rsvd;       // bit 4, reads 0
    logic vga_en;     // bit 3
    logic isa_en;     // bit 2
    logic serr_fwd;   // bit 1
    logic par_resp;   // bit 0
  } ctrl_t;

endpackage

// File: rtl/bfd_cfg_regs.sv
module bfd_cfg_regs
  import bfd_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctrl_we,
  input  logic [CTRL_W-1:0]   ctrl_wdata,
  input  logic                win_we,
  input  logic [AW-1:0]       win_base,
  input  logic [AW-1:0]       win_limit,
  output ctrl_t               ctrl_q,
  output logic [AW-1:0]       base_q,
  output logic [AW-1:0]       limit_q
);

  ctrl_t         ctrl_d;
  logic [AW-1:0] base_d;
  logic [AW-1:0] limit_d;

  always_comb begin
    ctrl_d      = ctrl_q;
    if (ctrl_we) begin
      ctrl_d      = ctrl_t'(ctrl_wdata);
      ctrl_d.rsvd = 1'b0;
    end
  end

  always_comb begin
    base_d  = base_q;
    limit_d = limit_q;
    if (win_we) begin
      base_d  = win_base;
      limit_d = win_limit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '1;
      limit_q <= '0;
    end else if (win_we) begin
      base_q  <= base_d;
      limit_q <= limit_d;
    end
  end

endmodule

// File: rtl/bfd_fwd_decode.sv
module bfd_fwd_decode #(
  parameter int AW        = 32,
  parameter int ISA_SPAN  = 'h10000,
  parameter int VGA_M_LO  = 'hA0000,
  parameter int VGA_M_HI  = 'hBFFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          isa_en,
  input  logic          vga_en,
  input  logic [AW-1:0] base_q,
  input  logic [AW-1:0] limit_q,
  input  logic          txn_valid,
  input  logic [AW-1:0] txn_addr,
  input  logic          txn_is_io,
  input  logic          txn_from_sec,
  output logic          dec_valid,
  output logic          fwd_down,
  output logic          fwd_up
);

  localparam int LOW_W = 10;
  localparam logic [LOW_W-1:0] VIO_A_LO = LOW_W'('h3B0);
  localparam logic [LOW_W-1:0] VIO_A_HI = LOW_W'('h3BB);
  localparam logic [LOW_W-1:0] VIO_B_LO = LOW_W'('h3C0);
  localparam logic [LOW_W-1:0] VIO_B_HI = LOW_W'('h3DF);

  logic [LOW_W-1:0] low_bits;
  logic             in_window;
  logic             below_isa;
  logic             isa_hole;
  logic             vga_io_hit;
  logic             vga_mem_hit;
  logic             down_claim;
  logic             valid_d, down_d, up_d;
  logic             flag_en;

  assign low_bits = txn_addr[LOW_W-1:0];

  // Address space smaller than the legacy span: everything is below it.
  generate
    if (AW > $clog2(ISA_SPAN)) begin : g_wide
      assign below_isa = (txn_addr < AW'(ISA_SPAN));
    end else begin : g_narrow
      assign below_isa = 1'b1;
    end
  endgenerate

  generate
    if (AW > $clog2(VGA_M_HI)) begin : g_vmem
      assign vga_mem_hit = vga_en && (txn_addr >= AW'(VGA_M_LO))
                                  && (txn_addr <= AW'(VGA_M_HI));
    end else begin : g_no_vmem
      assign vga_mem_hit = 1'b0;
    end
  endgenerate

  always_comb begin
    in_window  = (txn_addr >= base_q) && (txn_addr <= limit_q);
    isa_hole   = isa_en && below_isa && (low_bits[9:8] != 2'b00);
    vga_io_hit = vga_en &&
                 (((low_bits >= VIO_A_LO) && (low_bits <= VIO_A_HI)) ||
                  ((low_bits >= VIO_B_LO) && (low_bits <= VIO_B_HI)));
    if (txn_is_io) begin
      down_claim = vga_io_hit || (in_window && !isa_hole);
    end else begin
      down_claim = vga_mem_hit;
    end
  end

  always_comb begin
    valid_d = txn_valid;
    down_d  = txn_valid && !txn_from_sec && down_claim;
    up_d    = txn_valid &&  txn_from_sec && !down_claim;
    flag_en = txn_valid || dec_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
    end else begin
      dec_valid <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_down <= 1'b0;
      fwd_up   <= 1'b0;
    end else if (flag_en) begin
      fwd_down <= down_d;
      fwd_up   <= up_d;
    end
  end

endmodule

// File: rtl/bfd_err_policy.sv
module bfd_err_policy (
  input  logic ma_mode,
  input  logic serr_fwd,
  input  logic par_resp,
  input  logic sec_ma,
  input  logic sec_ma_read,
  input  logic pri_serr_en,
  input  logic sec_serr,
  input  logic sec_perr,
  output logic ma_fill_ones,
  output logic ma_drop_write,
  output logic ma_target_abort,
  output logic pri_serr,
  output logic perr_report
);

  logic hide_ma;
  logic serr_from_ma;
  logic serr_from_sec;

  always_comb begin
    hide_ma         = sec_ma && !ma_mode;
    ma_fill_ones    = hide_ma && sec_ma_read;
    ma_drop_write   = hide_ma && !sec_ma_read;
    ma_target_abort = sec_ma && ma_mode;
    serr_from_ma    = ma_target_abort && pri_serr_en;
    serr_from_sec   = sec_serr && serr_fwd;
    pri_serr        = serr_from_ma || serr_from_sec;
    perr_report     = sec_perr && par_resp;
  end

endmodule

// File: rtl/bridge_fwd_decoder.sv
module bridge_fwd_decoder
  import bfd_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  output logic [CTRL_W-1:0] ctrl_rdata,
  input  logic              win_we,
  input  logic [AW-1:0]     win_base,
  input  logic [AW-1:0]     win_limit,
  input  logic              txn_valid,
  input  logic [AW-1:0]     txn_addr,
  input  logic              txn_is_io,
  input  logic              txn_from_sec,
  output logic              dec_valid,
  output logic              fwd_down,
  output logic              fwd_up,
  input  logic              sec_ma,
  input  logic              sec_ma_read,
  input  logic              pri_serr_en,
  input  logic              sec_serr,
  input  logic              sec_perr,
  output logic              ma_fill_ones,
  output logic              ma_drop_write,
  output logic              ma_target_abort,
  output logic              pri_serr,
  output logic              perr_report
);

  ctrl_t         ctrl_q;
  logic [AW-1:0] base_q;
  logic [AW-1:0] limit_q;

  bfd_cfg_regs #(.AW(AW)) i_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_we    (ctrl_we),
    .ctrl_wdata (ctrl_wdata),
    .win_we     (win_we),
    .win_base   (win_base),
    .win_limit  (win_limit),
    .ctrl_q     (ctrl_q),
    .base_q     (base_q),
    .limit_q    (limit_q)
  );

  assign ctrl_rdata = ctrl_q;

  bfd_fwd_decode #(.AW(AW)) i_decode (
    .clk          (clk),
    .rst_n        (rst_n),
    .isa_en       (ctrl_q.isa_en),
    .vga_en       (ctrl_q.vga_en),
    .base_q       (base_q),
    .limit_q      (limit_q),
    .txn_valid    (txn_valid),
    .txn_addr     (txn_addr),
    .txn_is_io    (txn_is_io),
    .txn_from_sec (txn_from_sec),
    .dec_valid    (dec_valid),
    .fwd_down     (fwd_down),
    .fwd_up       (fwd_up)
  );

  bfd_err_policy i_err (
    .ma_mode         (ctrl_q.ma_mode),
    .serr_fwd        (ctrl_q.serr_fwd),
    .par_resp        (ctrl_q.par_resp),
    .sec_ma          (sec_ma),
    .sec_ma_read     (sec_ma_read),
    .pri_serr_en     (pri_serr_en),
    .sec_serr        (sec_serr),
    .sec_perr        (sec_perr),
    .ma_fill_ones    (ma_fill_ones),
    .ma_drop_write   (ma_drop_write),
    .ma_target_abort (ma_target_abort),
    .pri_serr        (pri_serr),
    .perr_report     (perr_report)
  );

endmodule

// File: rtl/bfd_checker.sv
module bfd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] ctrl_rdata,
  input logic       txn_valid,
  input logic       txn_from_sec,
  input logic       dec_valid,
  input logic       fwd_down,
  input logic       fwd_up,
  input logic       sec_ma,
  input logic       sec_ma_read,
  input logic       sec_serr,
  input logic       sec_perr,
  input logic       ma_fill_ones,
  input logic       ma_drop_write,
  input logic       ma_target_abort,
  input logic       pri_serr,
  input logic       perr_report
);

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_rdata[4]);

  a_r3_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |=> dec_valid);

  a_r3_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({fwd_down, fwd_up}) <= 1);

  a_r3_flags_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_down || fwd_up) |-> dec_valid);

  a_r6_down_from_primary: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && txn_from_sec |=> !fwd_down);

  a_r9_fill_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    ma_fill_ones |-> (sec_ma && sec_ma_read));

  a_r9_drop_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    ma_drop_write |-> (sec_ma && !sec_ma_read));

  a_r10_abort_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    ma_target_abort |-> (sec_ma && !ma_fill_ones && !ma_drop_write));

  a_r11_serr_source: assert property (@(posedge clk) disable iff (!rst_n)
    pri_serr |-> (sec_serr || ma_target_abort));

  a_r12_perr_source: assert property (@(posedge clk) disable iff (!rst_n)
    perr_report |-> sec_perr);

endmodule

bind bridge_fwd_decoder bfd_checker i_bfd_checker (
  .clk             (clk),
  .rst_n           (rst_n),
  .ctrl_rdata      (ctrl_rdata),
  .txn_valid       (txn_valid),
  .txn_from_sec    (txn_from_sec),
  .dec_valid       (dec_valid),
  .fwd_down        (fwd_down),
  .fwd_up          (fwd_up),
  .sec_ma          (sec_ma),
  .sec_ma_read     (sec_ma_read),
  .sec_serr        (sec_serr),
  .sec_perr        (sec_perr),
  .ma_fill_ones    (ma_fill_ones),
  .ma_drop_write   (ma_drop_write),
  .ma_target_abort (ma_target_abort),
  .pri_serr        (pri_serr),
  .perr_report     (perr_report)
);

// File: tb/test_bridge_fwd_decoder.sv
module test_bridge_fwd_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ctrl_we;
  logic [5:0]    ctrl_wdata;
  logic [5:0]    ctrl_rdata;
  logic          win_we;
  logic [AW-1:0] win_base, win_limit;
  logic          txn_valid;
  logic [AW-1:0] txn_addr;
  logic          txn_is_io, txn_from_sec;
  logic          dec_valid, fwd_down, fwd_up;
  logic          sec_ma, sec_ma_read, pri_serr_en, sec_serr, sec_perr;
  logic          ma_fill_ones, ma_drop_write, ma_target_abort, pri_serr, perr_report;

  int n_checks = 0;
  int n_errors = 0;
  string cur_req = "R4";

  // reference model state
  bit [5:0]         m_ctrl;
  longint unsigned  m_base, m_limit;
  bit               e_valid, e_down, e_up;

  always #(CLK_PERIOD/2) clk = ~clk;

  bridge_fwd_decoder #(.AW(AW)) i_bridge_fwd_decoder (.*);

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h (addr=%0h io=%0b sec=%0b ctrl=%0h)",
               req, what, act, exp, txn_addr, txn_is_io, txn_from_sec, m_ctrl);
    end
  endtask

  function automatic bit m_claim(input longint unsigned a, input bit io);
    longint unsigned off = a % 1024;
    bit vga = m_ctrl[3];
    bit isa = m_ctrl[2];
    if (!io) return vga && a >= 655360 && a <= 786431;
    if (vga && ((off >= 944 && off <= 955) || (off >= 960 && off <= 991))) return 1;
    if (!(a >= m_base && a <= m_limit)) return 0;
    if (isa && a < 65536 && off >= 256) return 0;
    return 1;
  endfunction

  // one clock: expectations use registers as they stood at the edge
  task automatic tick();
    @(posedge clk);
    e_valid = txn_valid;
    e_down  = txn_valid && !txn_from_sec &&  m_claim(txn_addr, txn_is_io);
    e_up    = txn_valid &&  txn_from_sec && !m_claim(txn_addr, txn_is_io);
    if (ctrl_we) m_ctrl = ctrl_wdata & 6'b101111;
    if (win_we) begin m_base = win_base; m_limit = win_limit; end
    @(negedge clk);
    check("R3", "dec_valid", dec_valid, e_valid);
    check(cur_req, "fwd_down", fwd_down, e_down);
    check(cur_req, "fwd_up", fwd_up, e_up);
    check("R2", "ctrl_rdata", ctrl_rdata, m_ctrl);
    // combinational error policy, current regs and inputs
    check(m_ctrl[5] ? "R10" : "R9", "ma_fill_ones", ma_fill_ones, sec_ma && !m_ctrl[5] && sec_ma_read);
    check(m_ctrl[5] ? "R10" : "R9", "ma_drop_write", ma_drop_write, sec_ma && !m_ctrl[5] && !sec_ma_read);
    check("R10", "ma_target_abort", ma_target_abort, sec_ma && m_ctrl[5]);
    check("R11", "pri_serr", pri_serr, (sec_serr && m_ctrl[1]) || (sec_ma && m_ctrl[5] && pri_serr_en));
    check("R12", "perr_report", perr_report, sec_perr && m_ctrl[0]);
    ctrl_we = 0; win_we = 0;
  endtask

  task automatic wr_ctrl(input bit [5:0] v);
    ctrl_we = 1; ctrl_wdata = v; txn_valid = 0; tick();
  endtask

  task automatic wr_win(input longint unsigned b, input longint unsigned l);
    win_we = 1; win_base = AW'(b); win_limit = AW'(l); txn_valid = 0; tick();
  endtask

  task automatic txn(input longint unsigned a, input bit io, input bit sec);
    txn_valid = 1; txn_addr = AW'(a); txn_is_io = io; txn_from_sec = sec; tick();
    txn_valid = 0;
  endtask

  task automatic both_sides(input longint unsigned a, input bit io);
    txn(a, io, 0); txn(a, io, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    int offs[12] = '{0, 'hFF, 'h100, 'h101, 'h3AF, 'h3B0, 'h3BB, 'h3BC, 'h3C0, 'h3DF, 'h3E0, 'h3FF};
    rst_n = 0; ctrl_we = 0; ctrl_wdata = 0; win_we = 0; win_base = 0; win_limit = 0;
    txn_valid = 0; txn_addr = 0; txn_is_io = 0; txn_from_sec = 0;
    sec_ma = 0; sec_ma_read = 0; pri_serr_en = 0; sec_serr = 0; sec_perr = 0;
    m_ctrl = 0; m_base = 64'hFFFF_FFFF; m_limit = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "ctrl_rdata in reset", ctrl_rdata, 0);
    check("R1", "dec_valid in reset", dec_valid, 0);
    check("R1", "fwd_down in reset", fwd_down, 0);
    check("R1", "fwd_up in reset", fwd_up, 0);
    rst_n = 1;
    tick();
    // R1: empty window claims nothing, secondary I/O all goes up
    cur_req = "R1";
    both_sides(0, 1); both_sides('h1000, 1); both_sides('hFFFF_FFFF, 1);

    // R2: reserved bit write ignored
    cur_req = "R2";
    wr_ctrl(6'b010000);
    check("R2", "reserved readback", ctrl_rdata[4], 0);
    txn('h3C0, 1, 0);

    // R4: window without suppression
    cur_req = "R4";
    wr_win('h1000, 'h1FFF);
    both_sides('h0FFF, 1); both_sides('h1000, 1); both_sides('h1500, 1);
    both_sides('h1FFF, 1); both_sides('h2000, 1);

    // R5 / R6: suppression holes, including the 64K edge
    cur_req = "R5";
    wr_win('hF000, 'h10FFF);
    for (int isa = 0; isa < 2; isa++) begin
      wr_ctrl(isa ? 6'b000100 : 6'b000000);
      for (int blk = 'h3C; blk < 'h44; blk++)
        for (int k = 0; k < 12; k++) begin
          cur_req = (k % 2) ? "R6" : "R5";
          both_sides(blk * 1024 + offs[k], 1);
        end
    end

    // R7: display I/O override, inside and outside window, with holes
    cur_req = "R7";
    wr_win('h400, 'h7FF);
    for (int c = 0; c < 4; c++) begin
      wr_ctrl({2'b00, c[1], c[0], 2'b00});
      for (int blk = 0; blk < 3; blk++)
        for (int k = 0; k < 12; k++) both_sides(blk * 1024 + offs[k], 1);
      both_sides('h2_03C4, 1);
    end

    // R8: memory transactions
    cur_req = "R8";
    for (int v = 0; v < 2; v++) begin
      wr_ctrl(v ? 6'b001000 : 6'b000000);
      both_sides('h9FFFF, 0); both_sides('hA0000, 0); both_sides('hB1234, 0);
      both_sides('hBFFFF, 0); both_sides('hC0000, 0); both_sides('h1000, 0);
    end

    // R9 / R10 / R11 / R12: error policy under every control combination
    cur_req = "R3";
    for (int c = 0; c < 64; c++) begin
      wr_ctrl(c[5:0]);
      for (int s = 0; s < 32; s++) begin
        sec_ma = s[0]; sec_ma_read = s[1]; pri_serr_en = s[2]; sec_serr = s[3]; sec_perr = s[4];
        tick();
      end
    end
    sec_ma = 0; sec_ma_read = 0; pri_serr_en = 0; sec_serr = 0; sec_perr = 0;

    // mixed random traffic with back-to-back transactions, R3 timing
    cur_req = "R6";
    for (int i = 0; i < 3000; i++) begin
      int sel = $urandom_range(0, 9);
      if (sel == 0) begin
        ctrl_we = 1; ctrl_wdata = 6'($urandom);
      end else if (sel == 1) begin
        int lo = $urandom_range(0, 80) * 1024;
        win_we = 1; win_base = AW'(lo); win_limit = AW'(lo + $urandom_range(0, 40000));
      end
      txn_valid = ($urandom_range(0, 3) != 0);
      case ($urandom_range(0, 2))
        0: txn_addr = AW'($urandom_range(0, 'h14000));
        1: txn_addr = AW'($urandom_range('h9F000, 'hC1000));
        default: txn_addr = $urandom;
      endcase
      txn_is_io = $urandom_range(0, 1); txn_from_sec = $urandom_range(0, 1);
      sec_ma = $urandom_range(0, 1); sec_ma_read = $urandom_range(0, 1);
      pri_serr_en = $urandom_range(0, 1); sec_serr = $urandom_range(0, 1);
      sec_perr = $urandom_range(0, 1);
      tick();
    end
    txn_valid = 0;
    tick(); tick();

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule